// File: doc/BRIEF.md
# Write-First Synchronous RAM with Output Clear

This block is a single-port synchronous memory whose read data passes through an output register. Each clock edge with the block enabled performs one operation: a read of the addressed word, or a write of the input word into the addressed location. On a write, the output register takes the newly written word instead of the old contents (write-first behaviour). Callers that need a read of the old contents must issue a separate read cycle before the write.

A synchronous clear input loads a constant, set by a parameter, into the output register and leaves the stored words alone. The clear ignores the address and the data input. When the block is disabled, nothing changes: no write takes place and the output register holds its value. Data width, address width and the clear constant are all parameters. The output register powers up holding the clear constant.

Top module: `wf_sram`

## Requirements
- R1: On an enabled edge with `writeEnable` low and `outClear` low, `wordOut` shows the word stored at `wordAddr` after that edge, and no stored word changes.
- R2: On an enabled edge with `writeEnable` high, the location at `wordAddr` is replaced by `wordIn`, and a later read of that address returns it.
- R3: On an enabled edge with `writeEnable` high and `outClear` low, `wordOut` shows `wordIn` after that edge, not the previous contents.
- R4: While `memEnable` is low, `wordOut` holds its value and no location is written, whatever `writeEnable`, `wordAddr` and `wordIn` are.
- R5: On an enabled edge with `outClear` high, `wordOut` becomes `RESET_WORD` after that edge, whatever `wordAddr` and `wordIn` are.
- R6: `outClear` never alters stored words. If `outClear` and `writeEnable` are both high on an enabled edge, the write still happens and the output shows `RESET_WORD`.
- R7: `outClear` has no effect while `memEnable` is low.
- R8: Before any clock edge, `wordOut` equals `RESET_WORD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation occurs on its rising edge |
| memEnable | input | 1 | Enables a read, write or clear on this edge |
| writeEnable | input | 1 | High selects a write, low selects a read |
| wordAddr | input | ADDR_W | Word address |
| wordIn | input | DATA_W | Word to be written |
| outClear | input | 1 | Synchronous load of RESET_WORD into the output register |
| wordOut | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is a clear that coincides with a write. The output then hides the written word, so the write can only be seen through a later read of the same address. The stimulus issues that combined cycle on a chosen address and then reads the address back. It also gives a clear with a random address and data, followed by a read, to show that no contents changed. A long random mix then sets enable, write, clear and address against each other on every clock, while the bench's shadow array predicts each output.

// File: rtl/wf_sram_pkg.sv
package wf_sram_pkg;

  // Source that the output register loads on the next edge
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_ARRAY = 2'd1,
    SEL_INPUT = 2'd2,
    SEL_CONST = 2'd3
  } outSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    memWrite;
    outSel_e outSel;
  } strobes_t;

endpackage

// File: rtl/wf_sram_ctrl.sv
module wf_sram_ctrl
  import wf_sram_pkg::*;
(
  input  logic     memEnable,
  input  logic     writeEnable,
  input  logic     outClear,
  output strobes_t strobes
);

  always_comb begin
    strobes.memWrite = memEnable & writeEnable;
    if (!memEnable)       strobes.outSel = SEL_HOLD;
    else if (outClear)    strobes.outSel = SEL_CONST;
    else if (writeEnable) strobes.outSel = SEL_INPUT;
    else                  strobes.outSel = SEL_ARRAY;
  end

endmodule

// File: rtl/wf_sram_dp.sv
module wf_sram_dp
  import wf_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wordIn,
  output logic [DATA_W-1:0] wordOut
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] storage [DEPTH];
  logic [DATA_W-1:0] outLatch = RESET_WORD;

  always_ff @(posedge clk) begin
    if (strobes.memWrite) storage[wordAddr] <= wordIn;
  end

  always_ff @(posedge clk) begin
    case (strobes.outSel)
      SEL_ARRAY: outLatch <= storage[wordAddr];
      SEL_INPUT: outLatch <= wordIn;
      SEL_CONST: outLatch <= RESET_WORD;
      default:   outLatch <= outLatch;
    endcase
  end

  assign wordOut = outLatch;

endmodule

// File: rtl/wf_sram.sv
module wf_sram
  import wf_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter logic [DATA_W-1:0] RESET_WORD = 16'h0101
) (
  input  logic              clk,
  input  logic              memEnable,
  input  logic              writeEnable,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              outClear,
  output logic [DATA_W-1:0] wordOut
);

  strobes_t strobes;

  wf_sram_ctrl i_ctrl (
    .memEnable  (memEnable),
    .writeEnable(writeEnable),
    .outClear   (outClear),
    .strobes    (strobes)
  );

  wf_sram_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .RESET_WORD(RESET_WORD)
  ) i_dp (
    .clk     (clk),
    .strobes (strobes),
    .wordAddr(wordAddr),
    .wordIn  (wordIn),
    .wordOut (wordOut)
  );

endmodule

// File: rtl/wf_sram_chk.sv
module wf_sram_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
  input logic              clk,
  input logic              memEnable,
  input logic              writeEnable,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [DATA_W-1:0] wordIn,
  input logic              outClear,
  input logic [DATA_W-1:0] wordOut
);

  // Stays low until the first edge so that $past has history
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R3
  p_write_first_r3: assert property (@(posedge clk) disable iff (!primed)
    (memEnable && writeEnable && !outClear) |=> (wordOut == $past(wordIn)));

  // R5
  p_clear_const_r5: assert property (@(posedge clk) disable iff (!primed)
    (memEnable && outClear) |=> (wordOut == RESET_WORD));

  // R4 and R7
  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!primed)
    (!memEnable) |=> $stable(wordOut));

  // R2 and R1: a write followed at once by a read of the same address
  p_read_after_write_r2: assert property (@(posedge clk) disable iff (!primed)
    (memEnable && writeEnable) ##1
    (memEnable && !writeEnable && !outClear && wordAddr == $past(wordAddr))
    |=> (wordOut == $past(wordIn, 2)));

endmodule

bind wf_sram wf_sram_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .RESET_WORD(RESET_WORD)
) i_chk (
  .clk        (clk),
  .memEnable  (memEnable),
  .writeEnable(writeEnable),
  .wordAddr   (wordAddr),
  .wordIn     (wordIn),
  .outClear   (outClear),
  .wordOut    (wordOut)
);

// File: tb/test_wf_sram.sv
module test_wf_sram;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] RST_WORD = 16'h0101;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              memEnable = 1'b0;
  logic              writeEnable = 1'b0;
  logic [ADDR_W-1:0] wordAddr = '0;
  logic [DATA_W-1:0] wordIn = '0;
  logic              outClear = 1'b0;
  logic [DATA_W-1:0] wordOut;

  int compared = 0;
  int mismatched = 0;

  logic [DATA_W-1:0] shadow [DEPTH];
  logic [DATA_W-1:0] expOut = RST_WORD;

  always #(CLK_PERIOD/2) clk = ~clk;

  wf_sram #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .RESET_WORD(RST_WORD)
  ) i_wf_sram (
    .clk        (clk),
    .memEnable  (memEnable),
    .writeEnable(writeEnable),
    .wordAddr   (wordAddr),
    .wordIn     (wordIn),
    .outClear   (outClear),
    .wordOut    (wordOut)
  );

  task automatic check(input logic [DATA_W-1:0] exp, input string req);
    compared++;
    if (wordOut !== exp) begin
      mismatched++;
      $display("FAIL %s: wordOut=%h expected=%h at %0t", req, wordOut, exp, $time);
    end
  endtask

  // Drive one cycle, update the reference model, compare after the edge
  task automatic step(input logic en, input logic we, input logic clr,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input string req);
    @(negedge clk);
    memEnable = en; writeEnable = we; outClear = clr; wordAddr = a; wordIn = d;
    if (en) begin
      if (clr)      expOut = RST_WORD;
      else if (we)  expOut = d;
      else          expOut = shadow[a];
      if (we) shadow[a] = d;
    end
    @(negedge clk);
    check(expOut, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog (all requirements): run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1;
    check(RST_WORD, "R8");

    // Fill: write-first output on every write
    for (int i = 0; i < DEPTH; i++)
      step(1, 1, 0, ADDR_W'(i), DATA_W'(16'hA500 ^ (i * 16'h0111)), "R3");
    // Read all back
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, 0, ADDR_W'(i), 16'hFFFF, "R1");
    step(1, 0, 0, 6'd5, 16'h0, "R2");

    // Disabled with write asserted: hold, then confirm no write
    step(1, 0, 0, 6'd9, 16'h0, "R1");
    step(0, 1, 0, 6'd9, 16'hDEAD, "R4");
    step(0, 1, 0, 6'd10, 16'hBEEF, "R4");
    step(1, 0, 0, 6'd9, 16'h0, "R4");
    step(1, 0, 0, 6'd10, 16'h0, "R4");

    // Clear with arbitrary address/data, then contents intact
    step(1, 0, 1, 6'd33, 16'h1234, "R5");
    step(1, 0, 0, 6'd33, 16'h0, "R6");
    step(1, 0, 1, 6'd63, 16'hFFFF, "R5");
    step(1, 0, 0, 6'd63, 16'h0, "R6");

    // Clear together with write: output constant, write lands
    step(1, 1, 1, 6'd17, 16'hCAFE, "R6");
    step(1, 0, 0, 6'd17, 16'h0, "R6");
    step(1, 0, 0, 6'd18, 16'h0, "R1");

    // Clear while disabled: ignored
    step(0, 0, 1, 6'd18, 16'h0, "R7");
    step(0, 1, 1, 6'd19, 16'h7777, "R7");
    step(1, 0, 0, 6'd19, 16'h0, "R7");

    // Write then immediate read of the same address
    step(1, 1, 0, 6'd0, 16'h5A5A, "R2");
    step(1, 0, 0, 6'd0, 16'h0, "R2");

    // Random mix
    for (int i = 0; i < 2000; i++)
      step(1'(($urandom % 4) != 0), 1'($urandom), 1'(($urandom % 8) == 0),
           ADDR_W'($urandom), DATA_W'($urandom), "R1..R7 mix");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule